// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 12-bit serial-input digital-to-analog converter. A host sends data over a three-wire serial port: a serial clock, serial data and a load strobe. An active-low select lets several converters share the clock and data lines. Bits enter a shift register that is separate from the output holding register, so a new word can be loaded without changing the code that drives the resistor ladder.

The holding register is loaded by level, not by edge. While the active-low load strobe is low, the output code follows the shift register, without waiting for any serial clock edge. An active-low clear forces the output code to zero at any time and takes priority over the strobe. The block also gives the output as a millivolt value for checking, at one millivolt per code step, so full scale is 4095 mV. A sticky error flag records serial clocking that happens while the strobe is still low.

All port inputs are treated as asynchronous to the system clock `clk`. They pass through synchronizers, and the serial clock is edge-detected in the `clk` domain. The serial clock must therefore run well below `clk`: each serial clock level must last at least three `clk` cycles.

Top module: `dac_serial_fe`

## Requirements
- R1: After synchronous reset `rst`, `dac_code`, `out_mv` and `proto_err` are zero, and the shift register holds zero.
- R2: On each rising edge of `sclk` while `cs_n` is low, the shift register moves one place toward the MSB and takes `sdin` into bit 0. Data therefore enters MSB first, and the register keeps the last 12 bits clocked in.
- R3: While `cs_n` is high, edges on `sclk` leave the shift register unchanged.
- R4: While `ldac_n` and `clr_n` are both high, `dac_code` keeps its value, whatever happens on the serial port.
- R5: While `ldac_n` is low and `clr_n` is high, `dac_code` follows the shift register within three `clk` cycles, with no `sclk` edge needed.
- R6: While `clr_n` is low, `dac_code` becomes and stays zero within three `clk` cycles, even if `ldac_n` is low.
- R7: `out_mv` equals `dac_code` times one millivolt; code 0xFFF gives 4095.
- R8: `proto_err` sets on a rising `sclk` edge seen while `cs_n` and `ldac_n` are both low. It then stays set until `rst`. An `sclk` edge while `cs_n` is high does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled; data shifts on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low select gating the serial port |
| ldac_n | input | 1 | Active-low, level-sensitive load strobe |
| clr_n | input | 1 | Active-low clear of the holding register |
| dac_code | output | 12 | Code driving the converter ladder |
| out_mv | output | 12 | Output level in millivolts |
| proto_err | output | 1 | Sticky flag for clocking while the strobe is low |

## Verification
The bench shifts words longer than twelve bits. A design that kept the first bits instead of the last, or shifted LSB first, would show the wrong code after the strobe. Clocking with the select high checks for a port that ignores the select: such a design would corrupt the word already shifted in. Holding clear low while the strobe is low, then releasing clear, checks clear priority and transparency. A design that latched on a strobe edge would stay at zero after clear is released, and one that let the strobe beat clear would show a nonzero code. Clocking with the strobe low checks that the code follows the live shift register and that the error flag sets only when the select is low.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned CODE_W_DEF = 12;
  localparam int unsigned SYNC_DEF   = 2;

  // Bit order of the synchronized control bundle
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_SDIN = 1;
  localparam int unsigned IDX_CS   = 2;
  localparam int unsigned IDX_LDAC = 3;
  localparam int unsigned IDX_CLR  = 4;
  localparam int unsigned CTRL_W   = 5;

  // Idle levels: clock low, data low, select/strobe/clear inactive (high)
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 5'b11100;

  function automatic int unsigned mv_width(int unsigned code_w, int unsigned mv_per_lsb);
    return $clog2(((1 << code_w) - 1) * mv_per_lsb + 1);
  endfunction
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= RST_VAL;
          else     stage[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= RST_VAL;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dac_fe_shifter.sv
module dac_fe_shifter #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdin_s,
  input  logic              cs_s,
  output logic              sclk_rise,
  output logic [CODE_W-1:0] shift_q
);
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (sclk_rise && !cs_s) begin
      shift_q <= {shift_q[CODE_W-2:0], sdin_s};
    end
  end
endmodule

// File: rtl/dac_fe_hold.sv
module dac_fe_hold #(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned MV_PER_LSB = 1,
  parameter int unsigned MV_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_s,
  input  logic              ldac_s,
  input  logic              cs_s,
  input  logic              sclk_rise,
  input  logic [CODE_W-1:0] shift_q,
  output logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   mv,
  output logic              err
);
  logic [CODE_W-1:0] code_nxt;

  // Clear beats the strobe; the strobe is a level, so the register tracks
  // the shift register on every clk while it is held low.
  always_comb begin
    code_nxt = code;
    if (!clr_s)       code_nxt = '0;
    else if (!ldac_s) code_nxt = shift_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      mv   <= '0;
    end else begin
      code <= code_nxt;
      mv   <= MV_W'(code_nxt * MV_PER_LSB);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   err <= 1'b0;
    else if (sclk_rise && !cs_s && !ldac_s)    err <= 1'b1;
  end
endmodule

// File: rtl/dac_serial_fe.sv
module dac_serial_fe
  import dac_fe_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter int unsigned MV_PER_LSB  = 1,
  localparam int unsigned MV_W       = mv_width(CODE_W, MV_PER_LSB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              cs_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] dac_code,
  output logic [MV_W-1:0]   out_mv,
  output logic              proto_err
);
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic sclk_s, sdin_s, cs_s, ldac_s, clr_s;
  logic sclk_rise;
  logic [CODE_W-1:0] shift_q;

  always_comb begin
    ctrl_raw           = '0;
    ctrl_raw[IDX_SCLK] = sclk;
    ctrl_raw[IDX_SDIN] = sdin;
    ctrl_raw[IDX_CS]   = cs_n;
    ctrl_raw[IDX_LDAC] = ldac_n;
    ctrl_raw[IDX_CLR]  = clr_n;
  end

  dac_fe_sync #(
    .WIDTH  (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTRL_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(ctrl_raw), .q(ctrl_s)
  );

  assign sclk_s = ctrl_s[IDX_SCLK];
  assign sdin_s = ctrl_s[IDX_SDIN];
  assign cs_s   = ctrl_s[IDX_CS];
  assign ldac_s = ctrl_s[IDX_LDAC];
  assign clr_s  = ctrl_s[IDX_CLR];

  dac_fe_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sdin_s(sdin_s), .cs_s(cs_s),
    .sclk_rise(sclk_rise), .shift_q(shift_q)
  );

  dac_fe_hold #(
    .CODE_W(CODE_W), .MV_PER_LSB(MV_PER_LSB), .MV_W(MV_W)
  ) u_hold (
    .clk(clk), .rst(rst), .clr_s(clr_s), .ldac_s(ldac_s), .cs_s(cs_s),
    .sclk_rise(sclk_rise), .shift_q(shift_q),
    .code(dac_code), .mv(out_mv), .err(proto_err)
  );
endmodule

// File: rtl/dac_serial_fe_chk.sv
module dac_serial_fe_chk #(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned MV_PER_LSB = 1,
  parameter int unsigned MV_W       = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_s,
  input logic              ldac_s,
  input logic              cs_s,
  input logic              sclk_rise,
  input logic [CODE_W-1:0] shift_q,
  input logic [CODE_W-1:0] dac_code,
  input logic [MV_W-1:0]   out_mv,
  input logic              proto_err
);
  // R3
  a_r3_select_gates_shift: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> $stable(shift_q));
  // R4
  a_r4_code_held: assert property (@(posedge clk) disable iff (rst)
    (clr_s && ldac_s) |=> $stable(dac_code));
  // R5
  a_r5_strobe_tracks: assert property (@(posedge clk) disable iff (rst)
    (clr_s && !ldac_s) |=> dac_code == $past(shift_q));
  // R6
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> dac_code == '0);
  // R7
  a_r7_mv_scale: assert property (@(posedge clk) disable iff (rst)
    32'(out_mv) == 32'(dac_code) * MV_PER_LSB);
  // R8
  a_r8_err_sets: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !cs_s && !ldac_s) |=> proto_err);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind dac_serial_fe dac_serial_fe_chk #(
  .CODE_W(CODE_W), .MV_PER_LSB(MV_PER_LSB), .MV_W(MV_W)
) u_chk (
  .clk(clk), .rst(rst), .clr_s(clr_s), .ldac_s(ldac_s), .cs_s(cs_s),
  .sclk_rise(sclk_rise), .shift_q(shift_q), .dac_code(dac_code),
  .out_mv(out_mv), .proto_err(proto_err)
);

// File: tb/test_dac_serial_fe.sv
module test_dac_serial_fe;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdin = 1'b0, cs_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
  logic [W-1:0] dac_code;
  logic [11:0]  out_mv;
  logic         proto_err;

  always #4 clk = ~clk; // 125 MHz

  dac_serial_fe i_dac_serial_fe (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .cs_n(cs_n),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(dac_code),
    .out_mv(out_mv), .proto_err(proto_err)
  );

  typedef struct {
    logic [W-1:0] code;
    logic         err;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic print_summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: push an expectation and wait for the monitor to consume it.
  task automatic expect_out(logic [W-1:0] code, logic err, string tag);
    exp_t e;
    e.code = code; e.err = err; e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    tick(1);
  endtask

  // Monitor: compare on the falling clock edge.
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() > 0);
      @(negedge clk);
      e = sb_q[0];
      n_chk += 3;
      if (dac_code !== e.code) begin
        n_bad++;
        $display("FAIL %s dac_code actual=%h expected=%h", e.tag, dac_code, e.code);
      end
      if (out_mv !== 12'(e.code)) begin
        n_bad++;
        $display("FAIL %s (R7) out_mv actual=%0d expected=%0d", e.tag, out_mv, e.code);
      end
      if (proto_err !== e.err) begin
        n_bad++;
        $display("FAIL %s (R8) proto_err actual=%b expected=%b", e.tag, proto_err, e.err);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic sclk_pulse(logic bit_v);
    sdin = bit_v;
    tick(4);
    sclk = 1'b1;
    tick(4);
    sclk = 1'b0;
    tick(4);
  endtask

  task automatic shift_bits(logic [31:0] val, int nbits);
    cs_n = 1'b0;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) sclk_pulse(val[i]);
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic strobe();
    ldac_n = 1'b0;
    tick(6);
    ldac_n = 1'b1;
    tick(6);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    expect_out(12'h000, 1'b0, "R1 reset state");

    shift_bits(32'hA5C, 12);
    expect_out(12'h000, 1'b0, "R4 code held during shift");
    ldac_n = 1'b0;
    tick(6);
    expect_out(12'hA5C, 1'b0, "R5 strobe low transfers");
    ldac_n = 1'b1;
    tick(6);
    expect_out(12'hA5C, 1'b0, "R4 held after strobe release");

    shift_bits(32'hF123, 16);
    expect_out(12'hA5C, 1'b0, "R4 unchanged before strobe");
    strobe();
    expect_out(12'h123, 1'b0, "R2 last twelve bits MSB first");

    for (int i = 0; i < 12; i++) sclk_pulse(1'b1);
    strobe();
    expect_out(12'h123, 1'b0, "R3 select high ignores clock");

    shift_bits(32'hFFF, 12);
    strobe();
    expect_out(12'hFFF, 1'b0, "R7 full scale 4095 mV");

    clr_n = 1'b0;
    tick(6);
    expect_out(12'h000, 1'b0, "R6 clear forces zero");
    ldac_n = 1'b0;
    tick(6);
    expect_out(12'h000, 1'b0, "R6 clear beats strobe");
    clr_n = 1'b1;
    tick(6);
    expect_out(12'hFFF, 1'b0, "R5 transparent after clear release");
    ldac_n = 1'b1;
    tick(6);

    clr_n = 1'b0;
    tick(6);
    clr_n = 1'b1;
    tick(6);
    shift_bits(32'h3C7, 12);
    expect_out(12'h000, 1'b0, "R4 zero held while shifting");
    strobe();
    expect_out(12'h3C7, 1'b0, "R2 word after clear");

    ldac_n = 1'b0;
    tick(6);
    sclk_pulse(1'b1); // select high: no shift, no error
    expect_out(12'h3C7, 1'b0, "R8 select high clock leaves flag clear");
    cs_n = 1'b0;
    tick(4);
    sclk_pulse(1'b0);
    cs_n = 1'b1;
    tick(6);
    expect_out(12'h78E, 1'b1, "R8 clock with strobe low sets flag");
    ldac_n = 1'b1;
    tick(6);
    expect_out(12'h78E, 1'b1, "R8 flag sticky");

    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(4);
    expect_out(12'h000, 1'b0, "R1 reset clears all");

    print_summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    print_summary();
    $finish;
  end
endmodule